// File: doc/BRIEF.md
# Bus Cycle Qualifier and Chip-Select Decoder

This block is the glue between a processor with a 16-bit address bus and
its RAM, ROM and I/O devices. The processor sends the upper address byte
(the bank) on the data bus while the bus phase input is low. The block
passes that byte through while the phase is low and holds it while the
phase is high. It forms a 24-bit address from the bank and the 16-bit
address and decodes it against three configurable address windows.

Each chip select is qualified by the processor's two address-status lines,
`vda` (data address valid) and `vpa` (program address valid), and never by
the bus phase. A select can therefore settle during phase-low and is
stable before the phase rises, which is what synchronous peripherals
need. Cycles in which neither status line is high carry a junk address.
The read-modify-write dummy cycle and the intermediate cycles of indexed
addressing are such cycles, and they select nothing.

Only the read and write strobes are qualified by phase-high, because the
data bus carries the bank byte during phase-low. An opcode-fetch flag
marks cycles in which both status lines are high. A parameter can bar the
I/O window from opcode fetches.

Top module: `bus_cycle_qualifier`

## Requirements
- R1: `ram_cs_n` and `rom_cs_n` go low only while `vda` or `vpa` is high. When both are low, all three selects are high whatever the address.
- R2: With `IO_NO_FETCH`=1 (the default), `io_cs_n` goes low only when `vda`=1 and `vpa`=0. An opcode fetch from inside the I/O window selects no device at all.
- R3: `opfetch` is high exactly when `vda`=1 and `vpa`=1, outside reset.
- R4: Selects do not depend on `phi`. The same address, bank byte and status give the same selects in phase-low and in phase-high.
- R5: `rd_n` is low only when `phi`=1, `rw`=1 and (`vda` or `vpa`). `wr_n` is low only when `phi`=1, `rw`=0 and (`vda` or `vpa`).
- R6: `addr_full` = {bank, `addr`}. The bank equals `data` while `phi`=0. On every rising `clk` edge with `phi`=0 the bank register loads `data`. While `phi`=1 the bank register holds, and `data` has no effect on `addr_full`.
- R7: The default windows are RAM 0x000000–0x3FFFFF, ROM 0x00E000–0x00FFFF and I/O 0x00D000–0x00D0FF. Priority is I/O over ROM over RAM, and at most one select is low.
- R8: While `rst_n` is low, every select and strobe is high, `opfetch` is low and the bank register is 0. The outputs follow their inputs from the second `clk` edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the bank byte |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi | input | 1 | Bus phase (1 = data phase) |
| addr | input | 16 | Processor address bus |
| data | input | 8 | Processor data bus (bank byte while phi=0) |
| rw | input | 1 | 1 = read, 0 = write |
| vda | input | 1 | Data address valid |
| vpa | input | 1 | Program address valid |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low |
| io_cs_n | output | 1 | I/O select, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| opfetch | output | 1 | Opcode-fetch cycle flag |
| addr_full | output | 24 | Decoded 24-bit address |

## Verification
A single cycle can be both an opcode fetch and an address inside the I/O
window, which overlaps the RAM window. Here the fetch bar (R2) and the
window priority (R7) compete. The bench forces this with `vda`=`vpa`=1 on
addresses in 0x00D0xx and expects `opfetch` high with all selects high.
The dummy cycle of a read-modify-write presents a write level together
with invalid status during phase-high. The bench checks that this cycle
gives neither a select nor a write strobe, and that the write strobe then
appears on the real write cycle.

// File: rtl/bcq_pkg.sv
package bcq_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_RAM  = 2'd1,
    RGN_ROM  = 2'd2,
    RGN_IO   = 2'd3
  } region_e;

  localparam int unsigned NUM_WINDOWS = 3;
  localparam int unsigned WIN_RAM = 0;
  localparam int unsigned WIN_ROM = 1;
  localparam int unsigned WIN_IO  = 2;
endpackage

// File: rtl/bcq_reset_sync.sv
module bcq_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bcq_bank_latch.sv
module bcq_bank_latch #(
  parameter int unsigned BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              phi,
  input  logic [BANK_W-1:0] data,
  output logic [BANK_W-1:0] bank_eff
);
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bank_d;
  logic              cap_en;

  // Capture only during the address phase.
  assign cap_en = ~phi;

  always_comb begin
    bank_d = bank_q;
    if (cap_en) begin
      bank_d = data;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bank_q <= '0;
    end else begin
      bank_q <= bank_d;
    end
  end

  // Transparent in the low phase, holding in the high phase.
  assign bank_eff = phi ? bank_q : data;

  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phi |=> $stable(bank_q))
    else $error("bank register changed during the data phase");
endmodule

// File: rtl/bcq_map_decode.sv
module bcq_map_decode
  import bcq_pkg::*;
#(
  parameter int unsigned FULL_W    = 24,
  parameter logic [FULL_W-1:0] RAM_LO = 24'h000000,
  parameter logic [FULL_W-1:0] RAM_HI = 24'h3FFFFF,
  parameter logic [FULL_W-1:0] ROM_LO = 24'h00E000,
  parameter logic [FULL_W-1:0] ROM_HI = 24'h00FFFF,
  parameter logic [FULL_W-1:0] IO_LO  = 24'h00D000,
  parameter logic [FULL_W-1:0] IO_HI  = 24'h00D0FF
) (
  input  logic [FULL_W-1:0] full_addr,
  output region_e           region
);
  localparam logic [FULL_W-1:0] LOS [NUM_WINDOWS] = '{RAM_LO, ROM_LO, IO_LO};
  localparam logic [FULL_W-1:0] HIS [NUM_WINDOWS] = '{RAM_HI, ROM_HI, IO_HI};

  logic [NUM_WINDOWS-1:0] hit;

  for (genvar w = 0; w < NUM_WINDOWS; w++) begin : g_win
    assign hit[w] = (full_addr >= LOS[w]) && (full_addr <= HIS[w]);
  end

  always_comb begin
    region = RGN_NONE;
    if (hit[WIN_IO]) begin
      region = RGN_IO;
    end else if (hit[WIN_ROM]) begin
      region = RGN_ROM;
    end else if (hit[WIN_RAM]) begin
      region = RGN_RAM;
    end
  end
endmodule

// File: rtl/bcq_qualify.sv
module bcq_qualify
  import bcq_pkg::*;
#(
  parameter bit IO_NO_FETCH = 1'b1
) (
  input  logic    clk,
  input  logic    live,
  input  region_e region,
  input  logic    phi,
  input  logic    rw,
  input  logic    vda,
  input  logic    vpa,
  output logic    ram_cs_n,
  output logic    rom_cs_n,
  output logic    io_cs_n,
  output logic    rd_n,
  output logic    wr_n,
  output logic    opfetch
);
  logic addr_ok;
  logic fetch;
  logic io_ok;

  assign addr_ok = vda | vpa;
  assign fetch   = vda & vpa;

  if (IO_NO_FETCH) begin : g_io_data_only
    assign io_ok = vda & ~vpa;
  end else begin : g_io_any
    assign io_ok = addr_ok;
  end

  always_comb begin
    ram_cs_n = ~(live & addr_ok & (region == RGN_RAM));
    rom_cs_n = ~(live & addr_ok & (region == RGN_ROM));
    io_cs_n  = ~(live & io_ok   & (region == RGN_IO));
    rd_n     = ~(live & phi & rw  & addr_ok);
    wr_n     = ~(live & phi & ~rw & addr_ok);
    opfetch  = live & fetch;
  end

  assert_junk_cycle_idle_R1: assert property (@(posedge clk) disable iff (!live)
    (!vda && !vpa) |-> (ram_cs_n && rom_cs_n && io_cs_n && wr_n && rd_n))
    else $error("device touched in an invalid-address cycle");

  assert_io_no_fetch_R2: assert property (@(posedge clk) disable iff (!live)
    (IO_NO_FETCH && vpa) |-> io_cs_n)
    else $error("I/O selected with program address valid");

  assert_strobe_phase_R5: assert property (@(posedge clk) disable iff (!live)
    !phi |-> (rd_n && wr_n))
    else $error("strobe outside the data phase");

  assert_single_select_R7: assert property (@(posedge clk) disable iff (!live)
    $onehot0({~ram_cs_n, ~rom_cs_n, ~io_cs_n}))
    else $error("more than one select active");
endmodule

// File: rtl/bus_cycle_qualifier.sv
module bus_cycle_qualifier
  import bcq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned BANK_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          IO_NO_FETCH = 1'b1,
  parameter logic [ADDR_W+BANK_W-1:0] RAM_LO = 24'h000000,
  parameter logic [ADDR_W+BANK_W-1:0] RAM_HI = 24'h3FFFFF,
  parameter logic [ADDR_W+BANK_W-1:0] ROM_LO = 24'h00E000,
  parameter logic [ADDR_W+BANK_W-1:0] ROM_HI = 24'h00FFFF,
  parameter logic [ADDR_W+BANK_W-1:0] IO_LO  = 24'h00D000,
  parameter logic [ADDR_W+BANK_W-1:0] IO_HI  = 24'h00D0FF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     phi,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [BANK_W-1:0]        data,
  input  logic                     rw,
  input  logic                     vda,
  input  logic                     vpa,
  output logic                     ram_cs_n,
  output logic                     rom_cs_n,
  output logic                     io_cs_n,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     opfetch,
  output logic [ADDR_W+BANK_W-1:0] addr_full
);
  localparam int unsigned FULL_W = ADDR_W + BANK_W;

  logic              rst_sync_n;
  logic [BANK_W-1:0] bank_eff;
  region_e           region;

  bcq_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bcq_bank_latch #(.BANK_W(BANK_W)) u_bank (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .phi        (phi),
    .data       (data),
    .bank_eff   (bank_eff)
  );

  assign addr_full = {bank_eff, addr};

  bcq_map_decode #(
    .FULL_W (FULL_W),
    .RAM_LO (RAM_LO), .RAM_HI (RAM_HI),
    .ROM_LO (ROM_LO), .ROM_HI (ROM_HI),
    .IO_LO  (IO_LO),  .IO_HI  (IO_HI)
  ) u_map (
    .full_addr (addr_full),
    .region    (region)
  );

  bcq_qualify #(.IO_NO_FETCH(IO_NO_FETCH)) u_qual (
    .clk      (clk),
    .live     (rst_sync_n),
    .region   (region),
    .phi      (phi),
    .rw       (rw),
    .vda      (vda),
    .vpa      (vpa),
    .ram_cs_n (ram_cs_n),
    .rom_cs_n (rom_cs_n),
    .io_cs_n  (io_cs_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .opfetch  (opfetch)
  );

  assert_reset_idle_R8: assert property (@(posedge clk)
    !rst_n |-> (ram_cs_n && rom_cs_n && io_cs_n && rd_n && wr_n && !opfetch))
    else $error("outputs active during reset");

  assert_fetch_flag_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    opfetch |-> (vda && vpa))
    else $error("opfetch without both status lines");
endmodule

// File: tb/tb_bus_cycle_qualifier.sv
module tb_bus_cycle_qualifier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        phi = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        rw = 1'b1;
  logic        vda = 1'b0;
  logic        vpa = 1'b0;
  logic        ram_cs_n, rom_cs_n, io_cs_n, rd_n, wr_n, opfetch;
  logic [23:0] addr_full;

  int checks = 0;
  int failures = 0;
  bit compare_on = 1'b0;

  // behavioural model state
  int          m_live_cnt = 0;
  logic [7:0]  m_bank = '0;

  always #5 clk = ~clk;

  bus_cycle_qualifier dut (
    .clk(clk), .rst_n(rst_n), .phi(phi), .addr(addr), .data(data),
    .rw(rw), .vda(vda), .vpa(vpa), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n),
    .io_cs_n(io_cs_n), .rd_n(rd_n), .wr_n(wr_n), .opfetch(opfetch),
    .addr_full(addr_full)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_live_cnt = 0;
      m_bank = '0;
    end else begin
      if (m_live_cnt >= 2 && !phi) m_bank = data;
      if (m_live_cnt < 2) m_live_cnt++;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected outputs from the requirements
  always @(negedge clk) begin
    if (compare_on) begin
      logic        live;
      logic [7:0]  b;
      logic [23:0] fa;
      logic        valid, in_io, in_rom, in_ram;
      logic [2:0]  exp_cs;
      logic [1:0]  exp_st;
      string       tag;
      live  = (m_live_cnt >= 2);
      b     = phi ? m_bank : data;
      fa    = {b, addr};
      valid = vda | vpa;
      in_io  = (fa >= 24'h00D000) && (fa <= 24'h00D0FF);
      in_rom = (fa >= 24'h00E000) && (fa <= 24'h00FFFF);
      in_ram = (fa <= 24'h3FFFFF);
      exp_cs = 3'b111;
      if (live && valid) begin
        if (in_io) begin
          if (vda && !vpa) exp_cs = 3'b011;
        end else if (in_rom) exp_cs = 3'b101;
        else if (in_ram) exp_cs = 3'b110;
      end
      exp_st = 2'b11;
      if (live && phi && valid) exp_st = rw ? 2'b01 : 2'b10;
      if (!live) tag = "R8";
      else if (!valid) tag = "R1";
      else if (in_io && vpa) tag = "R2";
      else tag = "R7";
      check(tag, "selects {io,rom,ram}", {io_cs_n, rom_cs_n, ram_cs_n}, exp_cs);
      check(live ? "R5" : "R8", "strobes {rd,wr}", {rd_n, wr_n}, exp_st);
      check(live ? "R3" : "R8", "opfetch", opfetch, live && vda && vpa);
      check("R6", "addr_full", addr_full, fa);
    end
  end

  task automatic cyc(logic p, logic [7:0] bk, logic [15:0] a, logic r, logic da, logic pa);
    phi = p; data = bk; addr = a; rw = r; vda = da; vpa = pa;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    compare_on = 1'b1;
    cyc(1'b1, 8'h00, 16'h0100, 1'b0, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 16'hE000, 1'b1, 1'b1, 1'b1);
    cyc(1'b1, 8'h00, 16'hD000, 1'b1, 1'b1, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1'b1, 8'h00, 16'h0100, 1'b0, 1'b1, 1'b0);

    // read-modify-write: read, dummy (invalid, write level), write
    cyc(1'b0, 8'h00, 16'h0200, 1'b1, 1'b1, 1'b0);
    cyc(1'b1, 8'h5A, 16'h0200, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 16'h0200, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 8'h77, 16'h0200, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 16'h0200, 1'b0, 1'b1, 1'b0);
    cyc(1'b1, 8'h78, 16'h0200, 1'b0, 1'b1, 1'b0);

    // opcode fetch from the I/O window (R2), then a data access there
    cyc(1'b0, 8'h00, 16'hD010, 1'b1, 1'b1, 1'b1);
    cyc(1'b1, 8'hEA, 16'hD010, 1'b1, 1'b1, 1'b1);
    cyc(1'b0, 8'h00, 16'hD010, 1'b1, 1'b1, 1'b0);
    cyc(1'b1, 8'h33, 16'hD010, 1'b1, 1'b1, 1'b0);

    // priority boundaries and bank above RAM (R7)
    cyc(1'b0, 8'h00, 16'hDFFF, 1'b1, 1'b0, 1'b1);
    cyc(1'b0, 8'h00, 16'hE000, 1'b1, 1'b0, 1'b1);
    cyc(1'b0, 8'h01, 16'hE000, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 8'h3F, 16'hFFFF, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 8'h40, 16'h0000, 1'b1, 1'b1, 1'b0);

    // R4 and R6: same selects in both phases, bank held in high phase
    begin
      logic [2:0]  cs_low;
      logic [23:0] fa_low;
      cyc(1'b0, 8'h00, 16'hE123, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      cs_low = {io_cs_n, rom_cs_n, ram_cs_n};
      fa_low = addr_full;
      cyc(1'b1, 8'h00, 16'hE123, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      check("R4", "select phase independence", {io_cs_n, rom_cs_n, ram_cs_n}, cs_low);
      data = 8'hC3;
      #1;
      check("R6", "bank held in data phase", addr_full, fa_low);
      @(posedge clk);
      #1;
    end

    // mixed patterns
    for (int i = 0; i < 600; i++) begin
      logic [7:0] bk;
      logic [1:0] sel;
      sel = 2'($urandom());
      bk  = (sel == 2'd3) ? 8'($urandom()) : {6'd0, sel[0], 1'b0} >> 1;
      cyc(1'(i % 2), bk, 16'($urandom()) | ((i % 5 == 0) ? 16'hD000 : 16'h0),
          1'($urandom()), 1'($urandom()), 1'($urandom()));
    end

    // reset re-entry mid-stream (R8)
    rst_n = 1'b0;
    cyc(1'b1, 8'h00, 16'hE000, 1'b1, 1'b1, 1'b1);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1'b1, 8'h00, 16'hE000, 1'b1, 1'b1, 1'b1);

    compare_on = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule